// File: doc/BRIEF.md
# Display Pipeline Run and Commit Sequencer

This block decides when a display pipeline's configuration becomes live, starts and stops the pipeline, and gathers the pipeline's events into one level interrupt. Software writes to a small word-addressed register port. The rest of the pipeline reports a frame-boundary pulse, a tearing-effect pulse, an underflow pulse and a vsync pulse. In return the block drives the active configuration word, a frame-start pulse and the interrupt line.

The block has two output modes. In continuous video mode, software writes go to a staging copy of the configuration. They reach the active configuration only when software requests an update: at the next frame boundary while the pipeline runs, or at once while it is stopped. In command mode there is no staging path. The active configuration is sampled at the moment the run bit goes from 0 to 1. Each run then produces one frame, optionally gated by a tearing-effect pulse, and the run bit clears when that frame ends.

Top module: `disp_seq_ctrl`

## Requirements
- R1: After reset, the control, status and enable registers read 0, `cfg_o` is 0, `frame_start_o` is 0 and `irq_o` is 0.
- R2: Register word addresses are fixed:
  - 0 is control: bit 0 run, bit 1 stop, bit 2 update.
  - 1 is mode: bit 0, where 1 selects command mode.
  - 2 is output control: bit 8 enables tearing-effect gating.
  - 3 is the staging configuration, which keeps its low CFG_W bits.
  - 4 is the active configuration, which is read-only.
  - 5 is the interrupt enable, with mask 0x37.
  - 6 is the interrupt clear, which reads as 0.
  - 7 is the interrupt status.
  - Unused bits read as 0.
- R3: In video mode, a staging write leaves `cfg_o` unchanged. An update request made while stopped reads back in control bit 2 after the write edge. On the next edge, `cfg_o` takes the staging value, bit 2 clears and status bit 4 sets.
- R4: In video mode while running, a pending update waits and is applied at the edge where `frame_end_i` is high.
- R5: In video mode, the stop bit is accepted only while running; a stop written while stopped has no effect and control reads 0. After an accepted stop, run stays set until a `frame_end_i` edge. At that edge, run and stop clear and status bit 0 sets.
- R6: In command mode, the update bit is ignored. `cfg_o` takes the staging value at the edge where run rises, and staging writes made while running have no effect on `cfg_o`.
- R7: In command mode with output-control bit 8 set, `frame_start_o` stays low until a `te_i` pulse and pulses the cycle after it. With bit 8 clear, `frame_start_o` pulses on the second edge after the run write.
- R8: In command mode, `frame_end_i` before the frame has started is ignored. After the frame starts, `frame_end_i` clears run and sets status bit 0.
- R9: `te_i` sets status bit 1, `underflow_i` sets bit 2 and `vsync_i` sets bit 5, whatever the enable register holds.
- R10: Writing ones to the clear register clears those status bits. A set event wins over a clear of the same bit in the same cycle.
- R11: `irq_o` is high exactly when some status bit is set and its enable bit is set.
- R12: In video mode, `frame_start_o` pulses for one cycle after the edge where run rises. It also pulses after each `frame_end_i` edge while running with no stop pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| frame_end_i | input | 1 | Frame boundary pulse from the pipeline |
| te_i | input | 1 | Tearing-effect pulse from the panel |
| underflow_i | input | 1 | Pixel underflow pulse |
| vsync_i | input | 1 | Vertical sync pulse |
| cfg_o | output | CFG_W | Active configuration |
| frame_start_o | output | 1 | One-cycle frame start pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
If the staging or active configuration is corrupted, it appears on `cfg_o` one edge after the commit event. The commit event is an update request, a frame boundary or a run rise, depending on the mode. A wrong sequencing state shows in three places: the control readback, where run, stop or update remain stuck; a missing or extra `frame_start_o` pulse in the cycle after the trigger; and status bit 0 or 4 not setting at the completion edge. All of these are visible within one or two cycles of the stimulus. Status corruption reaches `irq_o` combinationally once the matching enable bit is set.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int STS_W  = 6;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_OUTCTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAGE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd5;
  localparam logic [ADDR_W-1:0] A_ICLR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_ISTS   = 3'd7;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_STOP = 1;
  localparam int CTRL_UPD  = 2;
  localparam int OUT_TE_EN = 8;

  localparam int IRQ_DONE = 0;
  localparam int IRQ_TE   = 1;
  localparam int IRQ_UF   = 2;
  localparam int IRQ_UPD  = 4;
  localparam int IRQ_VS   = 5;
  localparam logic [STS_W-1:0] STS_MASK = 6'b110111;

  typedef enum logic [1:0] {CMD_IDLE, CMD_WAIT, CMD_ACTIVE} cmd_st_e;
endpackage

// File: rtl/disp_seq_regs.sv
module disp_seq_regs
  import disp_seq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              run_i,
  input  logic              stop_pend_i,
  input  logic              upd_pend_i,
  input  logic [CFG_W-1:0]  active_i,
  input  logic [STS_W-1:0]  sts_i,
  output logic              ctrl_wr_o,
  output logic [STS_W-1:0]  clr_mask_o,
  output logic              cmd_mode_o,
  output logic              te_en_o,
  output logic [CFG_W-1:0]  stage_o,
  output logic [STS_W-1:0]  en_o
);
  logic             mode_q, te_en_q;
  logic [CFG_W-1:0] stage_q;
  logic [STS_W-1:0] en_q;
  logic             wdata_unused;

  assign wdata_unused = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      te_en_q <= 1'b0;
      stage_q <= '0;
      en_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MODE:   mode_q  <= wdata_i[0];
        A_OUTCTL: te_en_q <= wdata_i[OUT_TE_EN];
        A_STAGE:  stage_q <= wdata_i[CFG_W-1:0];
        A_IEN:    en_q    <= wdata_i[STS_W-1:0] & STS_MASK;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_RUN]  = run_i;
        rdata_o[CTRL_STOP] = stop_pend_i;
        rdata_o[CTRL_UPD]  = upd_pend_i;
      end
      A_MODE:   rdata_o[0] = mode_q;
      A_OUTCTL: rdata_o[OUT_TE_EN] = te_en_q;
      A_STAGE:  rdata_o[CFG_W-1:0] = stage_q;
      A_ACTIVE: rdata_o[CFG_W-1:0] = active_i;
      A_IEN:    rdata_o[STS_W-1:0] = en_q;
      A_ISTS:   rdata_o[STS_W-1:0] = sts_i;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_wr_o  = we_i && (addr_i == A_CTRL);
  assign clr_mask_o = (we_i && (addr_i == A_ICLR)) ? wdata_i[STS_W-1:0] : '0;
  assign cmd_mode_o = mode_q;
  assign te_en_o    = te_en_q;
  assign stage_o    = stage_q;
  assign en_o       = en_q;
endmodule

// File: rtl/disp_seq_engine.sv
module disp_seq_engine
  import disp_seq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [2:0]       ctrl_bits_i,
  input  logic             cmd_mode_i,
  input  logic             te_en_i,
  input  logic [CFG_W-1:0] stage_i,
  input  logic             frame_end_i,
  input  logic             te_i,
  output logic             run_o,
  output logic             stop_pend_o,
  output logic             upd_pend_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             frame_start_o,
  output logic             evt_done_o,
  output logic             evt_upd_o
);
  logic             run_q, stop_q, upd_q, fs_q;
  logic [CFG_W-1:0] cfg_q;
  cmd_st_e          st_q, st_d;
  logic             run_rise, vid_stop_fire, upd_fire, cmd_go, cmd_fin;

  assign run_rise      = ctrl_wr_i && ctrl_bits_i[CTRL_RUN] && !run_q;
  assign vid_stop_fire = !cmd_mode_i && stop_q && run_q && frame_end_i;
  assign upd_fire      = !cmd_mode_i && upd_q && (!run_q || frame_end_i);
  assign cmd_go        = cmd_mode_i && (st_q == CMD_WAIT) && (!te_en_i || te_i);
  assign cmd_fin       = cmd_mode_i && (st_q == CMD_ACTIVE) && frame_end_i;

  always_comb begin
    st_d = st_q;
    if (!cmd_mode_i) st_d = CMD_IDLE;
    else begin
      case (st_q)
        CMD_IDLE:   if (run_rise) st_d = CMD_WAIT;
        CMD_WAIT:   if (cmd_go)   st_d = CMD_ACTIVE;
        CMD_ACTIVE: if (cmd_fin)  st_d = CMD_IDLE;
        default:    st_d = CMD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      upd_q  <= 1'b0;
      fs_q   <= 1'b0;
      cfg_q  <= '0;
      st_q   <= CMD_IDLE;
    end else begin
      st_q <= st_d;
      if (evt_done_o)    run_q <= 1'b0;
      else if (run_rise) run_q <= 1'b1;
      if (evt_done_o) stop_q <= 1'b0;
      else if (ctrl_wr_i && ctrl_bits_i[CTRL_STOP] && run_q && !cmd_mode_i) stop_q <= 1'b1;
      // a fresh request beats retirement so no write is lost
      if (ctrl_wr_i && ctrl_bits_i[CTRL_UPD] && !cmd_mode_i) upd_q <= 1'b1;
      else if (upd_fire) upd_q <= 1'b0;
      if (upd_fire)                      cfg_q <= stage_i;
      else if (cmd_mode_i && run_rise)   cfg_q <= stage_i;
      fs_q <= cmd_go ||
              (!cmd_mode_i && (run_rise || (run_q && frame_end_i && !stop_q)));
    end
  end

  assign evt_done_o    = vid_stop_fire || cmd_fin;
  assign evt_upd_o     = upd_fire;
  assign run_o         = run_q;
  assign stop_pend_o   = stop_q;
  assign upd_pend_o    = upd_q;
  assign cfg_o         = cfg_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/disp_seq_irq.sv
module disp_seq_irq
  import disp_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_done_i,
  input  logic             te_i,
  input  logic             underflow_i,
  input  logic             evt_upd_i,
  input  logic             vsync_i,
  input  logic [STS_W-1:0] clr_mask_i,
  input  logic [STS_W-1:0] en_i,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sts_q, set_v;

  always_comb begin
    set_v           = '0;
    set_v[IRQ_DONE] = evt_done_i;
    set_v[IRQ_TE]   = te_i;
    set_v[IRQ_UF]   = underflow_i;
    set_v[IRQ_UPD]  = evt_upd_i;
    set_v[IRQ_VS]   = vsync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_q & ~clr_mask_i) | set_v) & STS_MASK;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/disp_seq_ctrl.sv
module disp_seq_ctrl
  import disp_seq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_end_i,
  input  logic              te_i,
  input  logic              underflow_i,
  input  logic              vsync_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              frame_start_o,
  output logic              irq_o
);
  logic             ctrl_wr, cmd_mode, te_en, run, stop_pend, upd_pend;
  logic             evt_done, evt_upd;
  logic [STS_W-1:0] clr_mask, en, sts;
  logic [CFG_W-1:0] stage;

  disp_seq_regs #(.CFG_W(CFG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .run_i(run), .stop_pend_i(stop_pend), .upd_pend_i(upd_pend),
    .active_i(cfg_o), .sts_i(sts),
    .ctrl_wr_o(ctrl_wr), .clr_mask_o(clr_mask), .cmd_mode_o(cmd_mode),
    .te_en_o(te_en), .stage_o(stage), .en_o(en)
  );

  disp_seq_engine #(.CFG_W(CFG_W)) u_engine (
    .clk_i, .rst_ni,
    .ctrl_wr_i(ctrl_wr), .ctrl_bits_i(reg_wdata_i[2:0]),
    .cmd_mode_i(cmd_mode), .te_en_i(te_en), .stage_i(stage),
    .frame_end_i, .te_i,
    .run_o(run), .stop_pend_o(stop_pend), .upd_pend_o(upd_pend),
    .cfg_o, .frame_start_o,
    .evt_done_o(evt_done), .evt_upd_o(evt_upd)
  );

  disp_seq_irq u_irq (
    .clk_i, .rst_ni,
    .evt_done_i(evt_done), .te_i, .underflow_i, .evt_upd_i(evt_upd), .vsync_i,
    .clr_mask_i(clr_mask), .en_i(en), .sts_o(sts), .irq_o
  );
endmodule

// File: rtl/disp_seq_ctrl_chk.sv
module disp_seq_ctrl_chk
  import disp_seq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              te_i,
  input logic              cmd_mode,
  input logic              te_en,
  input logic              run,
  input logic              upd_pend,
  input logic [CFG_W-1:0]  stage,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [STS_W-1:0]  sts,
  input logic              frame_start_o
);
  logic [STS_W-1:0] clr_seen;
  logic             upd_wr;
  assign clr_seen = (reg_we_i && reg_addr_i == A_ICLR) ? reg_wdata_i[STS_W-1:0] : '0;
  assign upd_wr   = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[CTRL_UPD];

  AST_UPD_IDLE_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_mode && upd_pend && !run && !upd_wr) |=> !upd_pend); // R3
  AST_CMD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_mode && $past(cmd_mode) && $rose(run)) |-> cfg_o == $past(stage)); // R6
  AST_CMD_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_mode && $past(cmd_mode) && !$rose(run)) |-> $stable(cfg_o)); // R6
  AST_TE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_mode && te_en && !te_i) |=> !frame_start_o); // R7
  AST_RUN_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> sts[IRQ_DONE]); // R5
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sts) & ~sts & ~$past(clr_seen)) == '0)); // R10
endmodule

bind disp_seq_ctrl disp_seq_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .te_i,
  .cmd_mode, .te_en, .run, .upd_pend, .stage, .cfg_o, .sts, .frame_start_o
);

// File: tb/disp_seq_ctrl_test.sv
module disp_seq_ctrl_test;
  import disp_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 16;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              fe = 1'b0, te = 1'b0, uf = 1'b0, vs = 1'b0;
  logic [CFG_W-1:0]  cfg;
  logic              fs, irq;
  int                checks = 0, errors = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_seq_ctrl #(.CFG_W(CFG_W)) uut (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .frame_end_i(fe), .te_i(te), .underflow_i(uf), .vsync_i(vs),
    .cfg_o(cfg), .frame_start_o(fs), .irq_o(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [66:0] VEC [8] = '{
    {3'd1, 32'h0000_0001, 32'h0000_0001},
    {3'd1, 32'hFFFF_FFFE, 32'h0000_0000},
    {3'd2, 32'hFFFF_FFFF, 32'h0000_0100},
    {3'd2, 32'h0000_0000, 32'h0000_0000},
    {3'd5, 32'hFFFF_FFFF, 32'h0000_0037},
    {3'd5, 32'h0000_0000, 32'h0000_0000},
    {3'd3, 32'h1234_ABCD, 32'h0000_ABCD},
    {3'd6, 32'h0000_00FF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fe();
    @(negedge clk); fe = 1'b1;
    @(negedge clk); fe = 1'b0;
  endtask

  task automatic pulse_te();
    @(negedge clk); te = 1'b1;
    @(negedge clk); te = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    rd(A_CTRL, r); check("R1 ctrl", r, 0);
    rd(A_ISTS, r); check("R1 sts", r, 0);
    rd(A_IEN, r);  check("R1 en", r, 0);
    check("R1 cfg", 32'(cfg), 0);
    check("R1 fs", 32'(fs), 0);
    check("R1 irq", 32'(irq), 0);

    // R2 register map walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], r);
      check("R2 readback", r, VEC[i][31:0]);
    end

    // R3 video update while stopped
    wr(A_STAGE, 32'h1234);
    check("R3 stage no effect", 32'(cfg), 0);
    wr(A_CTRL, 32'h4);
    check("R3 cfg held", 32'(cfg), 0);
    rd(A_CTRL, r); check("R3 upd pending", r, 32'h4);
    tick(1);
    check("R3 cfg applied", 32'(cfg), 32'h1234);
    rd(A_CTRL, r); check("R3 upd cleared", r, 0);
    rd(A_ISTS, r); check("R3 upd status", r, 32'h10);
    wr(A_ICLR, 32'h3F);

    // R12 run start pulse
    wr(A_CTRL, 32'h1);
    check("R12 fs on run", 32'(fs), 1);
    tick(1);
    check("R12 fs single", 32'(fs), 0);

    // R4 update waits for frame boundary
    wr(A_STAGE, 32'hBEEF);
    wr(A_CTRL, 32'h4);
    tick(3);
    check("R4 cfg waits", 32'(cfg), 32'h1234);
    rd(A_CTRL, r); check("R4 ctrl pending", r, 32'h5);
    pulse_fe();
    check("R4 cfg at boundary", 32'(cfg), 32'hBEEF);
    check("R12 fs on frame end", 32'(fs), 1);
    rd(A_ISTS, r); check("R4 upd status", r, 32'h10);
    wr(A_ICLR, 32'h3F);

    // R5 video stop
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, r); check("R5 stop pending", r, 32'h3);
    tick(3);
    rd(A_CTRL, r); check("R5 still running", r, 32'h3);
    rd(A_ISTS, r); check("R5 no done yet", r, 0);
    pulse_fe();
    rd(A_CTRL, r); check("R5 stopped", r, 0);
    rd(A_ISTS, r); check("R5 done status", r, 32'h1);
    check("R12 no fs when stopping", 32'(fs), 0);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, r); check("R5 stop ignored idle", r, 0);

    // R11 interrupt gating (status bit 0 set)
    check("R11 masked", 32'(irq), 0);
    wr(A_IEN, 32'h1);
    check("R11 enabled", 32'(irq), 1);
    wr(A_IEN, 32'h10);
    check("R11 other enable", 32'(irq), 0);
    wr(A_ICLR, 32'h1);
    rd(A_ISTS, r); check("R10 clear", r, 0);

    // R9 event bits
    @(negedge clk); te = 1'b1; uf = 1'b1; vs = 1'b1;
    @(negedge clk); te = 1'b0; uf = 1'b0; vs = 1'b0;
    rd(A_ISTS, r); check("R9 events", r, 32'h26);
    wr(A_ICLR, 32'h02);
    rd(A_ISTS, r); check("R10 partial clear", r, 32'h24);
    wr(A_ICLR, 32'h3F);

    // R10 set wins over clear
    @(negedge clk); we = 1'b1; addr = A_ICLR; wdata = 32'h4; uf = 1'b1;
    @(negedge clk); we = 1'b0; uf = 1'b0;
    rd(A_ISTS, r); check("R10 set wins", r, 32'h4);
    wr(A_ICLR, 32'h3F);

    // R6 command mode capture
    wr(A_MODE, 32'h1);
    wr(A_OUTCTL, 32'h100);
    wr(A_STAGE, 32'h0A0A);
    wr(A_CTRL, 32'h4);
    tick(2);
    check("R6 update ignored", 32'(cfg), 32'hBEEF);
    rd(A_CTRL, r); check("R6 upd bit ignored", r, 0);
    wr(A_CTRL, 32'h1);
    check("R6 captured on run", 32'(cfg), 32'h0A0A);
    check("R7 no fs before te", 32'(fs), 0);
    tick(3);
    check("R7 waits for te", 32'(fs), 0);
    pulse_fe();
    rd(A_CTRL, r); check("R8 early frame end ignored", r, 32'h1);
    wr(A_STAGE, 32'h5555);
    pulse_te();
    check("R7 fs after te", 32'(fs), 1);
    tick(1);
    check("R7 fs single", 32'(fs), 0);
    check("R6 staging no effect", 32'(cfg), 32'h0A0A);
    wr(A_ICLR, 32'h3F);
    pulse_fe();
    rd(A_CTRL, r); check("R8 run cleared", r, 0);
    rd(A_ISTS, r); check("R8 done status", r, 32'h1);

    // R7 without te gating
    wr(A_OUTCTL, 32'h0);
    wr(A_CTRL, 32'h1);
    check("R6 second capture", 32'(cfg), 32'h5555);
    check("R7 fs not yet", 32'(fs), 0);
    tick(1);
    check("R7 fs ungated", 32'(fs), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule